// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Sequencer

This block holds the trap-related control state of a processor hart that runs only in machine mode. Each cycle it looks at a packed trap request word. When the word's active flag is set, it records the return address, the cause code and the trap value, pushes the interrupt-enable state onto the one-level stack in the status register, and issues a redirect to the handler address taken from the trap-vector register. A return request pops that stack and redirects to the saved return address.

Software reaches the five registers through a flat CSR port. The port uses the standard machine CSR addresses. Writes take effect at the clock edge and reads are combinational. Writes to the status register pass through a fixed field mask, and reads of it are filtered by the same mask. A separate load strobe captures a fault value ahead of an exception, and the next exception consumes that value.

Top module: `mtrap_ctrl`

## Requirements
- R1: After reset every readable CSR (status 0x300, trap-vector 0x305, return address 0x341, cause 0x342, trap value 0x343) reads zero, `priv` is 3 and `redirect_valid` is low.
- R2: A trap fires when bit 31 of `trap_word` is 1. If bits 15:0 are zero, the trap is an exception: the return address takes `cur_pc`, the trap value takes the captured fault value, and the captured fault value then becomes zero.
- R3: If bits 15:0 of a firing `trap_word` are nonzero, the trap is an interrupt: the return address takes `next_pc` and the trap value is left unchanged.
- R4: The cause register takes bit 31 = 1 for an interrupt and 0 for an exception, with the 15-bit cause from `trap_word` bits 30:16 zero-extended into the low bits. An exception with cause 11 is recorded as 8 + 3 = 11.
- R5: On a trap the status fields change as follows: MPP (bits 12:11) becomes 3, MPIE (bit 7) takes the old MIE (bit 3), and MIE becomes 0. `priv` becomes 3.
- R6: The redirect target is the trap-vector register with bit 0 cleared. When bit 0 of the trap-vector register is 1 and the trap is an interrupt, 4 × cause is added to the target. Exceptions never receive the offset.
- R7: On a return (`mret_req`): `priv` takes MPP, MPP becomes 0, MIE takes MPIE, MPIE is unchanged, and the target is the return-address register.
- R8: A CSR write to the status register changes only the bits set in 0x807FF9DD. A read of it returns the register ANDed with 0x807FF9DD.
- R9: `redirect_valid` is high for exactly the one cycle after each accepted trap or return, with `redirect_pc` valid in that cycle. A trap and a return in the same cycle are resolved as the trap alone.
- R10: A CSR write in a cycle that also carries a trap or a return has no effect. A read of any other address returns zero.
- R11: `fault_we` loads `fault_data` into the captured fault value, which the next exception copies to the trap value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_word | input | 32 | Packed trap request: active[31], cause[30:16], id[15:0] |
| cur_pc | input | 32 | Address of the current instruction |
| next_pc | input | 32 | Address of the next instruction |
| fault_we | input | 1 | Capture strobe for the fault value |
| fault_data | input | 32 | Fault value to capture |
| mret_req | input | 1 | Machine return request |
| csr_we | input | 1 | CSR write enable |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | 32 | Redirect target |
| priv | output | 2 | Current privilege code |

## Verification
A trap request, a return request and a software CSR write can all land in the same cycle. The bench provokes this by driving an interrupt, `mret_req` and a write to the return-address register together. It judges the result from several outputs. The return-address register must hold `next_pc` and not the written data. The status register must show the trap push and not the return pop. The redirect must point at the vectored interrupt handler and not at the saved return address.

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl #(
  parameter logic [31:0] MST_WMASK = 32'h807F_F9DD,
  parameter logic [1:0]  MACH_PRIV = 2'd3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] trap_word,
  input  logic [31:0] cur_pc,
  input  logic [31:0] next_pc,
  input  logic        fault_we,
  input  logic [31:0] fault_data,
  input  logic        mret_req,
  input  logic        csr_we,
  input  logic [11:0] csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        redirect_valid,
  output logic [31:0] redirect_pc,
  output logic [1:0]  priv
);
  localparam logic [11:0] A_STAT  = 12'h300;
  localparam logic [11:0] A_TVEC  = 12'h305;
  localparam logic [11:0] A_EPC   = 12'h341;
  localparam logic [11:0] A_CAUSE = 12'h342;
  localparam logic [11:0] A_TVAL  = 12'h343;
  localparam logic [14:0] ECALL   = 15'd11;

  logic [31:0] mst, epc_q, cause_q, tval_q, tvec_q, fault_q, tgt_q;
  logic [1:0]  priv_q;
  logic        rv_q;

  wire        trap_fire = trap_word[31];
  wire [14:0] cause_in  = trap_word[30:16];
  wire        is_irq    = |trap_word[15:0];
  wire        exc_fire  = trap_fire & ~is_irq;
  wire        ret_fire  = mret_req & ~trap_fire;
  wire        csr_wen   = csr_we & ~trap_fire & ~ret_fire;

  wire [14:0] cause_eff = (!is_irq && cause_in == ECALL) ? 15'd8 + {13'd0, MACH_PRIV} : cause_in;
  wire [31:0] vec_base  = {tvec_q[31:1], 1'b0};
  wire [31:0] vec_off   = (tvec_q[0] && is_irq) ? {15'd0, cause_eff, 2'b00} : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mst     <= '0;
      epc_q   <= '0;
      cause_q <= '0;
      tval_q  <= '0;
      tvec_q  <= '0;
      fault_q <= '0;
      tgt_q   <= '0;
      priv_q  <= MACH_PRIV;
      rv_q    <= 1'b0;
    end else begin
      rv_q <= trap_fire | ret_fire;
      if (fault_we) fault_q <= fault_data;
      if (trap_fire) begin
        tgt_q     <= vec_base + vec_off;
        cause_q   <= {is_irq, 16'd0, cause_eff};
        mst[12:11] <= MACH_PRIV;
        mst[7]    <= mst[3];
        mst[3]    <= 1'b0;
        priv_q    <= MACH_PRIV;
        if (is_irq) begin
          epc_q <= next_pc;
        end else begin
          epc_q   <= cur_pc;
          tval_q  <= fault_q;
          fault_q <= '0;
        end
      end else if (ret_fire) begin
        tgt_q      <= epc_q;
        priv_q     <= mst[12:11];
        mst[12:11] <= 2'b00;
        mst[3]     <= mst[7];
      end else if (csr_wen) begin
        case (csr_addr)
          A_STAT:  mst     <= (mst & ~MST_WMASK) | (csr_wdata & MST_WMASK);
          A_TVEC:  tvec_q  <= csr_wdata;
          A_EPC:   epc_q   <= csr_wdata;
          A_CAUSE: cause_q <= csr_wdata;
          A_TVAL:  tval_q  <= csr_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (csr_addr)
      A_STAT:  csr_rdata = mst & MST_WMASK;
      A_TVEC:  csr_rdata = tvec_q;
      A_EPC:   csr_rdata = epc_q;
      A_CAUSE: csr_rdata = cause_q;
      A_TVAL:  csr_rdata = tval_q;
      default: csr_rdata = '0;
    endcase
  end

  assign redirect_valid = rv_q;
  assign redirect_pc    = tgt_q;
  assign priv           = priv_q;

  p_fault_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_fire |=> fault_q == 32'd0);

  p_trap_stack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> (mst[12:11] == MACH_PRIV) && !mst[3] && (mst[7] == $past(mst[3])) && (priv == MACH_PRIV));

  p_mret_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> (priv == $past(mst[12:11])) && (mst[12:11] == 2'b00) && (redirect_pc == $past(epc_q)));

  p_mask_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wen && csr_addr == A_STAT) |=> ((mst & MST_WMASK) == ($past(csr_wdata) & MST_WMASK)));

  p_strobe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_fire || ret_fire) |=> !redirect_valid);

  p_write_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && (trap_fire || mret_req) && csr_addr == A_TVEC) |=> $stable(tvec_q));
endmodule

// File: tb/sim_mtrap_ctrl.sv
module sim_mtrap_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] trap_word = '0, cur_pc = '0, next_pc = '0, fault_data = '0, csr_wdata = '0;
  logic        fault_we = 1'b0, mret_req = 1'b0, csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_rdata, redirect_pc;
  logic        redirect_valid;
  logic [1:0]  priv;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mtrap_ctrl u0 (.clk(clk), .rst_n(rst_n), .trap_word(trap_word), .cur_pc(cur_pc),
    .next_pc(next_pc), .fault_we(fault_we), .fault_data(fault_data), .mret_req(mret_req),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .priv(priv));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic chk_csr(string tag, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic trap(logic [31:0] w, logic [31:0] pc, logic [31:0] npc);
    trap_word = w; cur_pc = pc; next_pc = npc;
    @(negedge clk);
    trap_word = '0;
  endtask

  task automatic mret();
    mret_req = 1'b1;
    @(negedge clk);
    mret_req = 1'b0;
  endtask

  task automatic t_reset();
    chk_csr("R1 status", 12'h300, 0);
    chk_csr("R1 tvec", 12'h305, 0);
    chk_csr("R1 epc", 12'h341, 0);
    chk_csr("R1 cause", 12'h342, 0);
    chk_csr("R1 tval", 12'h343, 0);
    chk("R1 priv", {30'd0, priv}, 3);
    chk("R1 rv", {31'd0, redirect_valid}, 0);
  endtask

  task automatic t_mask();
    wr(12'h300, 32'hFFFF_FFFF);
    chk_csr("R8 masked set", 12'h300, 32'h807F_F9DD);
    wr(12'h300, 32'h0000_0000);
    chk_csr("R8 masked clear", 12'h300, 0);
    chk_csr("R10 unknown addr", 12'h7C0, 0);
  endtask

  task automatic t_exception();
    wr(12'h305, 32'h0000_1001);
    wr(12'h300, 32'h0000_0008);
    fault_we = 1'b1; fault_data = 32'h0000_DEAD;
    @(negedge clk);
    fault_we = 1'b0;
    trap({1'b1, 15'd2, 16'd0}, 32'h100, 32'h104);
    chk("R9 strobe", {31'd0, redirect_valid}, 1);
    chk("R6 exc no offset", redirect_pc, 32'h1000);
    chk_csr("R2 epc", 12'h341, 32'h100);
    chk_csr("R11 tval", 12'h343, 32'hDEAD);
    chk_csr("R4 cause exc", 12'h342, 2);
    chk_csr("R5 stack", 12'h300, 32'h1880);
    @(negedge clk);
    chk("R9 strobe drop", {31'd0, redirect_valid}, 0);
    trap({1'b1, 15'd5, 16'd0}, 32'h200, 32'h204);
    chk_csr("R2 fault cleared", 12'h343, 0);
    chk_csr("R5 mpie from mie0", 12'h300, 32'h1800);
  endtask

  task automatic t_interrupt();
    wr(12'h300, 32'h0000_0008);
    wr(12'h343, 32'h55);
    trap({1'b1, 15'd7, 16'd1}, 32'h300, 32'h304);
    chk("R6 vectored", redirect_pc, 32'h101C);
    chk_csr("R3 epc next", 12'h341, 32'h304);
    chk_csr("R3 tval kept", 12'h343, 32'h55);
    chk_csr("R4 cause irq", 12'h342, 32'h8000_0007);
    wr(12'h305, 32'h0000_2000);
    trap({1'b1, 15'd5, 16'd3}, 32'h300, 32'h308);
    chk("R6 direct", redirect_pc, 32'h2000);
  endtask

  task automatic t_ecall();
    trap({1'b1, 15'd11, 16'd0}, 32'h400, 32'h404);
    chk_csr("R4 ecall cause", 12'h342, 11);
  endtask

  task automatic t_mret();
    wr(12'h300, 32'h0000_1880);
    wr(12'h341, 32'h0000_0800);
    mret();
    chk("R7 target", redirect_pc, 32'h800);
    chk("R9 mret strobe", {31'd0, redirect_valid}, 1);
    chk("R7 priv from mpp", {30'd0, priv}, 3);
    chk_csr("R7 status pop", 12'h300, 32'h88);
    mret();
    chk("R7 priv zero", {30'd0, priv}, 0);
    chk_csr("R7 status again", 12'h300, 32'h88);
  endtask

  task automatic t_collide();
    wr(12'h305, 32'h0000_3001);
    wr(12'h341, 32'h0000_0900);
    wr(12'h300, 32'h0000_1088);
    trap_word = {1'b1, 15'd3, 16'd2}; cur_pc = 32'hA00; next_pc = 32'hA04;
    mret_req = 1'b1; csr_we = 1'b1; csr_addr = 12'h341; csr_wdata = 32'hBEEF;
    @(negedge clk);
    trap_word = '0; mret_req = 1'b0; csr_we = 1'b0;
    chk("R9 trap wins target", redirect_pc, 32'h300C);
    chk_csr("R10 write ignored", 12'h341, 32'hA04);
    chk_csr("R9 trap push", 12'h300, 32'h1880);
    chk("R9 priv", {30'd0, priv}, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_exception();
    t_interrupt();
    t_ecall();
    t_mret();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule